// File: doc/BRIEF.md
# Banked Candidate Position Table

This block serves the history lookup of a wide streaming compressor. Every cycle it takes a window of `LANES` lanes. Each lane carries an optional request made of a hash value and the byte position of that lane in the stream. For each request it returns the positions last recorded under the same hash, up to `DEPTH` of them, newest first. In the same access it records the lane's own position as the newest entry for that hash. The stream is later compared at these positions to find repeated strings.

Storage is split into `BANKS` banks, and the low bits of the hash select the bank. Each bank serves two requests per cycle. Requests beyond that are dropped and marked as dropped, so the pipeline never stalls. Requests travel through a crossbar to the bank ports. The banks read their old contents and write new contents in the same cycle. The results then pass back through a second crossbar to the lanes they came from. A window presented before clock edge k has its results at the outputs after edge k+3, and a new window is accepted on every cycle.

Top module: `cand_table`

## Requirements
- R1: A request goes to bank `hash % BANKS`, which is the low `log2(BANKS)` bits of the hash. It uses the entry at row `hash >> log2(BANKS)` of that bank. Entries differing in bank or row never affect each other.
- R2: Each bank grants at most two requests per window. The two lowest-numbered valid lanes that target a bank win. Any further lane on that bank gets `out_kept`=0 and all of its `out_hit` bits at 0.
- R3: A dropped request leaves the table unchanged. A later lookup of its hash shows no trace of its position.
- R4: A granted request returns the contents of the entry from before its own write, then stores its position as the newest slot. A never-written slot returns `out_hit`=0, and `out_cand`=0 wherever `out_hit` is 0.
- R5: Slot d of a lane (d = 0 is newest) returns the position written by the (d+1)-th most recent granted write to that entry. A write pushes the oldest slot out. Lane l, slot d lives at `out_hit[l*DEPTH+d]` and `out_cand[(l*DEPTH+d)*POS_W +: POS_W]`.
- R6: When two granted lanes hit the same entry in one window, the lower lane reads the old contents. The higher lane sees the lower lane's position in slot 0 and the older slots shifted down by one. After the window the higher lane's position is newest.
- R7: Results for a window appear exactly 3 edges after the window is captured, with `out_vld` repeating `in_vld`. Back-to-back windows see each other's writes in window order.
- R8: Reset empties every entry and clears all outputs.
- R9: A lane with `in_vld`=0 makes no request, takes no bank port from higher lanes, and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | LANES | Request enable per lane |
| in_hash | input | LANES*HASH_W | Hash value per lane, lane 0 in the low bits |
| in_pos | input | LANES*POS_W | Stream position per lane |
| out_vld | output | LANES | Delayed request enable per lane |
| out_kept | output | LANES | Lane was granted a bank port |
| out_hit | output | LANES*DEPTH | Slot holds a recorded position |
| out_cand | output | LANES*DEPTH*POS_W | Recorded positions, zero where no hit |

## Verification
The assertions take for granted that inputs hold known values at every edge out of reset. Lane order is also taken as position order inside a window, because arbitration by lane index only means "smallest position wins" under that condition. The stimulus gives lane l of each window the position base+l and advances base by the lane count, so positions always rise with the lane index. Hashes are drawn from a narrow range so that bank conflicts, same-entry pairs and drops happen often.

// File: rtl/cand_table.sv
module cand_table #(
  parameter int LANES  = 4,
  parameter int BANKS  = 4,
  parameter int HASH_W = 8,
  parameter int POS_W  = 16,
  parameter int DEPTH  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             in_vld,
  input  logic [LANES*HASH_W-1:0]      in_hash,
  input  logic [LANES*POS_W-1:0]       in_pos,
  output logic [LANES-1:0]             out_vld,
  output logic [LANES-1:0]             out_kept,
  output logic [LANES*DEPTH-1:0]       out_hit,
  output logic [LANES*DEPTH*POS_W-1:0] out_cand
);
  localparam int BB   = $clog2(BANKS);
  localparam int RW   = HASH_W - BB;
  localparam int ROWS = 1 << RW;
  localparam int BSL  = 2 * DEPTH;

  logic [LANES-1:0]  s1_vld, s2_vld, s3_vld, s2_gnt, s3_gnt, s2_port, s3_port;
  logic [HASH_W-1:0] s1_hash [LANES];
  logic [HASH_W-1:0] s2_hash [LANES];
  logic [POS_W-1:0]  s1_pos  [LANES];
  logic [POS_W-1:0]  s2_pos  [LANES];
  logic [BB-1:0]     s3_bank [LANES];
  logic [LANES-1:0]  a_gnt, a_port;

  logic              bp_act [BANKS][2];
  logic [RW-1:0]     bp_row [BANKS][2];
  logic [POS_W-1:0]  bp_pos [BANKS][2];

  logic [BANKS*BSL*POS_W-1:0] q_pos;
  logic [BANKS*BSL-1:0]       q_ok;
  logic [LANES*DEPTH-1:0]       o_hit;
  logic [LANES*DEPTH*POS_W-1:0] o_cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= '0;
      for (int l = 0; l < LANES; l++) begin
        s1_hash[l] <= '0;
        s1_pos[l]  <= '0;
      end
    end else begin
      s1_vld <= in_vld;
      for (int l = 0; l < LANES; l++) begin
        s1_hash[l] <= in_hash[l*HASH_W +: HASH_W];
        s1_pos[l]  <= in_pos[l*POS_W +: POS_W];
      end
    end
  end

  always_comb begin
    int n;
    for (int l = 0; l < LANES; l++) begin
      n = 0;
      for (int j = 0; j < l; j++)
        if (s1_vld[j] && s1_hash[j][BB-1:0] == s1_hash[l][BB-1:0]) n++;
      a_gnt[l]  = s1_vld[l] && (n < 2);
      a_port[l] = (n == 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= '0;
      s2_gnt  <= '0;
      s2_port <= '0;
      for (int l = 0; l < LANES; l++) begin
        s2_hash[l] <= '0;
        s2_pos[l]  <= '0;
      end
    end else begin
      s2_vld  <= s1_vld;
      s2_gnt  <= a_gnt;
      s2_port <= a_port;
      for (int l = 0; l < LANES; l++) begin
        s2_hash[l] <= s1_hash[l];
        s2_pos[l]  <= s1_pos[l];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BANKS; b++)
      for (int p = 0; p < 2; p++) begin
        bp_act[b][p] = 1'b0;
        bp_row[b][p] = '0;
        bp_pos[b][p] = '0;
      end
    for (int l = 0; l < LANES; l++)
      if (s2_gnt[l]) begin
        bp_act[s2_hash[l][BB-1:0]][s2_port[l]] = 1'b1;
        bp_row[s2_hash[l][BB-1:0]][s2_port[l]] = s2_hash[l][HASH_W-1:BB];
        bp_pos[s2_hash[l][BB-1:0]][s2_port[l]] = s2_pos[l];
      end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [POS_W-1:0] tp [ROWS][DEPTH];
    logic [DEPTH-1:0] tk [ROWS];
    logic [DEPTH-1:0][POS_W-1:0] v0p, v1p, n0p, n1p;
    logic [DEPTH-1:0] v0k, v1k, n0k, n1k;
    logic [1:0][DEPTH-1:0][POS_W-1:0] r_pos;
    logic [1:0][DEPTH-1:0] r_ok;
    logic [LANES-1:0] gm0, gm1;
    logic same;

    assign same = bp_act[b][0] && bp_row[b][0] == bp_row[b][1];

    always_comb begin
      v1p = '0;
      v1k = '0;
      for (int d = 0; d < DEPTH; d++) v0p[d] = tp[bp_row[b][0]][d];
      v0k = tk[bp_row[b][0]];
      if (same) begin
        v1p[0] = bp_pos[b][0];
        v1k[0] = 1'b1;
        for (int d = 1; d < DEPTH; d++) begin
          v1p[d] = v0p[d-1];
          v1k[d] = v0k[d-1];
        end
      end else begin
        for (int d = 0; d < DEPTH; d++) v1p[d] = tp[bp_row[b][1]][d];
        v1k = tk[bp_row[b][1]];
      end
      n0p[0] = bp_pos[b][0];
      n0k[0] = 1'b1;
      n1p[0] = bp_pos[b][1];
      n1k[0] = 1'b1;
      for (int d = 1; d < DEPTH; d++) begin
        n0p[d] = v0p[d-1];
        n0k[d] = v0k[d-1];
        n1p[d] = v1p[d-1];
        n1k[d] = v1k[d-1];
      end
    end

    always_ff @(posedge clk) begin
      if (bp_act[b][0])
        for (int d = 0; d < DEPTH; d++) tp[bp_row[b][0]][d] <= n0p[d];
      if (bp_act[b][1])
        for (int d = 0; d < DEPTH; d++) tp[bp_row[b][1]][d] <= n1p[d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < ROWS; r++) tk[r] <= '0;
        r_pos <= '0;
        r_ok  <= '0;
      end else begin
        if (bp_act[b][0]) tk[bp_row[b][0]] <= n0k;
        if (bp_act[b][1]) tk[bp_row[b][1]] <= n1k;
        r_pos[0] <= v0p;
        r_pos[1] <= v1p;
        r_ok[0]  <= v0k;
        r_ok[1]  <= v1k;
      end
    end

    assign q_pos[b*BSL*POS_W +: BSL*POS_W] = r_pos;
    assign q_ok[b*BSL +: BSL] = r_ok;

    always_comb
      for (int l = 0; l < LANES; l++) begin
        gm0[l] = s2_gnt[l] && s2_hash[l][BB-1:0] == BB'(b) && !s2_port[l];
        gm1[l] = s2_gnt[l] && s2_hash[l][BB-1:0] == BB'(b) &&  s2_port[l];
      end

    a_r2_port_single: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gm0) <= 1 && $countones(gm1) <= 1);

    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (same && bp_act[b][1]) |=> (r_ok[1][0] && r_pos[1][0] == $past(bp_pos[b][0])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_vld  <= '0;
      s3_gnt  <= '0;
      s3_port <= '0;
      for (int l = 0; l < LANES; l++) s3_bank[l] <= '0;
    end else begin
      s3_vld  <= s2_vld;
      s3_gnt  <= s2_gnt;
      s3_port <= s2_port;
      for (int l = 0; l < LANES; l++) s3_bank[l] <= s2_hash[l][BB-1:0];
    end
  end

  always_comb begin
    int idx;
    o_hit  = '0;
    o_cand = '0;
    for (int l = 0; l < LANES; l++)
      for (int d = 0; d < DEPTH; d++) begin
        idx = (int'(s3_bank[l]) * 2 + int'(s3_port[l])) * DEPTH + d;
        if (s3_gnt[l] && q_ok[idx]) begin
          o_hit[l*DEPTH+d] = 1'b1;
          o_cand[(l*DEPTH+d)*POS_W +: POS_W] = q_pos[idx*POS_W +: POS_W];
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_kept <= '0;
      out_hit  <= '0;
      out_cand <= '0;
    end else begin
      out_vld  <= s3_vld;
      out_kept <= s3_gnt;
      out_hit  <= o_hit;
      out_cand <= o_cand;
    end
  end

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> out_vld == $past(in_vld, 4));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    a_r2_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[l] && !out_kept[l]) |-> out_hit[l*DEPTH +: DEPTH] == '0);
    a_r9_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld[l] |-> (!out_kept[l] && out_hit[l*DEPTH +: DEPTH] == '0));
    a_r5_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
      (DEPTH'(out_hit[l*DEPTH +: DEPTH] + DEPTH'(1)) & out_hit[l*DEPTH +: DEPTH]) == '0);
  end
endmodule

// File: tb/sim_cand_table.sv
`timescale 1ns/1ps
module sim_cand_table;
  localparam int L = 4, B = 4, H = 8, P = 16, D = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [L-1:0]     in_vld;
  logic [L*H-1:0]   in_hash;
  logic [L*P-1:0]   in_pos;
  logic [L-1:0]     out_vld, out_kept;
  logic [L*D-1:0]   out_hit;
  logic [L*D*P-1:0] out_cand;

  cand_table #(.LANES(L), .BANKS(B), .HASH_W(H), .POS_W(P), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_hash(in_hash), .in_pos(in_pos),
    .out_vld(out_vld), .out_kept(out_kept), .out_hit(out_hit), .out_cand(out_cand));

  always #10 clk = ~clk;

  typedef struct {
    string            tag;
    logic [L-1:0]     vld;
    logic [L-1:0]     kept;
    logic [L*D-1:0]   hit;
    logic [L*D*P-1:0] cand;
    int               due;
  } item_t;

  item_t q[$];
  item_t mon_it;
  logic [P-1:0] m_pos [0:(1<<H)-1][0:D-1];
  logic [D-1:0] m_ok  [0:(1<<H)-1];
  int cyc = 0, nchk = 0, nbad = 0;
  logic [P-1:0] base;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < (1 << H); i++) begin
      m_ok[i] = '0;
      for (int d = 0; d < D; d++) m_pos[i][d] = '0;
    end
  endtask

  function automatic logic [L*H-1:0] hx(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] e);
    return {e, c, b, a};
  endfunction

  task automatic step(string tag, logic [L-1:0] v, logic [L*H-1:0] h);
    item_t it;
    int n, hl;
    @(negedge clk);
    in_vld  = v;
    in_hash = h;
    for (int l = 0; l < L; l++) in_pos[l*P +: P] = base + P'(l);
    it.tag = tag; it.vld = v; it.kept = '0; it.hit = '0; it.cand = '0;
    for (int l = 0; l < L; l++) begin
      if (v[l]) begin
        hl = int'(h[l*H +: H]);
        n = 0;
        for (int j = 0; j < l; j++)
          if (v[j] && (int'(h[j*H +: H]) % B) == (hl % B)) n++;
        if (n < 2) begin
          it.kept[l] = 1'b1;
          for (int d = 0; d < D; d++)
            if (m_ok[hl][d]) begin
              it.hit[l*D+d] = 1'b1;
              it.cand[(l*D+d)*P +: P] = m_pos[hl][d];
            end
          for (int d = D - 1; d > 0; d--) begin
            m_pos[hl][d] = m_pos[hl][d-1];
            m_ok[hl][d]  = m_ok[hl][d-1];
          end
          m_pos[hl][0] = base + P'(l);
          m_ok[hl][0]  = 1'b1;
        end
      end
    end
    base = base + P'(L);
    it.due = cyc + 4;
    q.push_back(it);
  endtask

  task automatic drain();
    step("idle", '0, '0);
    while (q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0 && q[0].due == cyc) begin
      mon_it = q.pop_front();
      chk(mon_it.tag, "out_vld",  out_vld,  mon_it.vld);
      chk(mon_it.tag, "out_kept", out_kept, mon_it.kept);
      chk(mon_it.tag, "out_hit",  out_hit,  mon_it.hit);
      chk(mon_it.tag, "out_cand", out_cand, mon_it.cand);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = '0; in_hash = '0; in_pos = '0; base = 16'h0100;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset out_vld",  out_vld,  '0);
    chk("R8", "reset out_kept", out_kept, '0);
    chk("R8", "reset out_hit",  out_hit,  '0);
    chk("R8", "reset out_cand", out_cand, '0);

    step("R4", 4'b0001, hx(8'h05, 0, 0, 0));
    step("R4", 4'b0001, hx(8'h05, 0, 0, 0));
    step("R5", 4'b0001, hx(8'h05, 0, 0, 0));
    step("R5", 4'b0001, hx(8'h05, 0, 0, 0));
    step("R1", 4'b0011, hx(8'h04, 8'h06, 0, 0));
    step("R1", 4'b0011, hx(8'h08, 8'h04, 0, 0));
    step("R1", 4'b0001, hx(8'h06, 0, 0, 0));
    step("R2", 4'b1111, hx(8'h22, 8'h26, 8'h2A, 8'h2E));
    step("R3", 4'b0001, hx(8'h2A, 0, 0, 0));
    step("R3", 4'b0001, hx(8'h2E, 0, 0, 0));
    step("R3", 4'b0001, hx(8'h22, 0, 0, 0));
    step("R6", 4'b0011, hx(8'h33, 8'h33, 0, 0));
    step("R6", 4'b0001, hx(8'h33, 0, 0, 0));
    step("R6", 4'b0111, hx(8'h37, 8'h37, 8'h37, 0));
    step("R6", 4'b0001, hx(8'h37, 0, 0, 0));
    step("R9", 4'b1110, hx(8'h03, 8'h07, 8'h0B, 8'h0F));
    step("R9", 4'b0001, hx(8'h0F, 0, 0, 0));
    step("R9", 4'b0001, hx(8'h03, 0, 0, 0));
    for (int i = 0; i < 4; i++) step("R7", 4'b0001, hx(8'h41, 0, 0, 0));
    drain();

    @(negedge clk) rst_n = 1'b0;
    clear_model();
    repeat (2) @(negedge clk);
    chk("R8", "mid reset out_vld", out_vld, '0);
    chk("R8", "mid reset out_hit", out_hit, '0);
    rst_n = 1'b1;
    step("R8", 4'b0001, hx(8'h05, 0, 0, 0));
    step("R8", 4'b0001, hx(8'h33, 0, 0, 0));

    for (int i = 0; i < 400; i++)
      step("R7", L'($urandom_range(0, 15)),
           hx(8'($urandom_range(0, 15)), 8'($urandom_range(0, 15)),
              8'($urandom_range(0, 15)), 8'($urandom_range(0, 15))));
    drain();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule